// File: doc/BRIEF.md
# Card ID EEPROM Read Mailbox

This block lets a processor read the identification EEPROM of up to three plug-in interface cards through two 16-bit register locations, without driving any serial EEPROM pins. Software first writes a card-select code to the select location. It then writes a two-word serial-EEPROM read command to the command location and reads one 16-bit word back from that same location. The word holds two consecutive bytes from the selected card's ID store.

The ID contents and the card-present flags are held inside the block. A separate configuration port loads them: one byte per write, plus a presence vector. A read of the select location reports which cards are present. Every read result is combinational from registered state, so it is valid in the same cycle as the read strobe. A read of the command location consumes the pending result at the clock edge that ends the strobe.

Top module: `card_id_mailbox`

## Requirements
- R1: After reset no command is pending, the command word counter is at word 0, no card is selected and no card is marked present. A read of location 0x12 returns 0xFFFF and a read of location 0x42 returns 0xFFFF.
- R2: Each write to location 0x42 stores the next command word. Only the write that completes the second word sets the pending flag, and the counter then wraps to word 0. After one word only, a read of 0x42 returns 0xFFFF.
- R3: A read of 0x42 while a command is pending returns the EEPROM data and clears the pending flag. A read with nothing pending returns 0xFFFF.
- R4: A write to location 0x12 loads the card select. 0x1700 picks card 0, 0x1D00 picks card 1 and 0x3500 picks card 2. Any other value picks no card, and a command result is then 0xFFFF.
- R5: The byte address is bits 5:0 of the first command word (a read command is 0x180 plus the address). All other bits of the first word, and the whole second word, have no effect on the result.
- R6: The result carries the byte at the address in bits 15:8 and the byte at address+1 in bits 7:0. Address+1 wraps from 63 to 0 within the card's 64-byte store.
- R7: When the selected card is not marked present, the command result is 0xFFFF even if its store holds data.
- R8: A read of 0x12 returns 0xFFFF with bit n cleared when card n is marked present, for n from 0 to 2.
- R9: Read data is valid in the same cycle as the read strobe, with no added latency.
- R10: A read of any other location returns 0x0000. A write to any other location changes neither the select, the command state nor the presence flags.
- R11: On the configuration port, a byte write stores a byte at a given card and address, and a presence write loads all presence flags at once. Both take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register location of the access |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_rd | input | 1 | Read strobe, one cycle per word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| cfg_byte_we | input | 1 | Store one ID byte |
| cfg_card | input | 2 | Card index for the byte store |
| cfg_addr | input | 6 | Byte address for the byte store |
| cfg_byte | input | 8 | Byte value to store |
| cfg_present_we | input | 1 | Load the presence flags |
| cfg_present | input | 3 | Presence flags, bit n for card n |

## Verification
Read data is due in the same cycle as the read strobe. The bench therefore samples `bus_rdata` on the falling edge inside that strobe cycle, with no pipeline offset. Writes to select, command, presence and ID bytes take effect at the rising edge that ends their strobe. The bench always issues the next access at least one full cycle later. Consumption of a pending result happens at the rising edge after the read strobe, so the follow-up read that expects 0xFFFF is issued in a later cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   // Register locations decoded by the mailbox
   localparam logic [7:0] LOC_SELECT  = 8'h12;
   localparam logic [7:0] LOC_COMMAND = 8'h42;

   localparam int MAX_CARDS = 3;

   // Select code that picks card idx
   function automatic logic [15:0] select_code(input int idx);
      case (idx)
         0:       select_code = 16'h1700;
         1:       select_code = 16'h1D00;
         2:       select_code = 16'h3500;
         default: select_code = 16'h0000;
      endcase
   endfunction

endpackage

// File: rtl/mbx_cmd_seq.sv
// Command word sequencer: counts command words, captures the byte address
// from word 0 and raises the pending flag when the last word lands.
module mbx_cmd_seq #(
   parameter  int CMD_WORDS = 2,
   parameter  int AW        = 6,
   localparam int PW        = (CMD_WORDS > 1) ? $clog2(CMD_WORDS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb,
   input  logic          rd_stb,
   input  logic [AW-1:0] addr_in,
   output logic          cmd_valid,
   output logic [PW-1:0] word_pos,
   output logic [AW-1:0] byte_addr
);

   localparam logic [PW-1:0] LAST_POS = PW'(CMD_WORDS - 1);

   if (CMD_WORDS < 1) begin : g_bad_words
      $error("mbx_cmd_seq: CMD_WORDS must be at least 1");
   end
   if (AW < 1) begin : g_bad_aw
      $error("mbx_cmd_seq: AW must be at least 1");
   end

   logic at_last;
   assign at_last = (word_pos == LAST_POS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_pos  <= '0;
         byte_addr <= '0;
         cmd_valid <= 1'b0;
      end else begin
         if (wr_stb) begin
            if (word_pos == '0) begin
               byte_addr <= addr_in;
            end
            word_pos <= at_last ? '0 : word_pos + 1'b1;
         end
         // Completion of a command wins over a same-cycle consume
         if (wr_stb && at_last) begin
            cmd_valid <= 1'b1;
         end else if (rd_stb) begin
            cmd_valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/mbx_sel_decode.sv
// Card select register: decodes the written code on write and keeps
// the hit flag and card index registered.
module mbx_sel_decode #(
   parameter  int NUM_CARDS = 3,
   parameter  int DATA_W    = 16,
   localparam int IDX_W     = (NUM_CARDS > 1) ? $clog2(NUM_CARDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wdata,
   output logic              sel_hit,
   output logic [IDX_W-1:0]  sel_idx
);

   import mbx_pkg::*;

   if (NUM_CARDS < 1 || NUM_CARDS > MAX_CARDS) begin : g_bad_cards
      $error("mbx_sel_decode: NUM_CARDS out of range");
   end
   if (DATA_W < 16) begin : g_bad_width
      $error("mbx_sel_decode: select codes need DATA_W of at least 16");
   end

   logic [NUM_CARDS-1:0] code_match;

   for (genvar gi = 0; gi < NUM_CARDS; gi++) begin : g_match
      assign code_match[gi] = (wdata == DATA_W'(select_code(gi)));
   end

   logic [IDX_W-1:0] next_idx;

   always_comb begin
      next_idx = '0;
      for (int i = NUM_CARDS - 1; i >= 0; i--) begin
         if (code_match[i]) begin
            next_idx = IDX_W'(i);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_hit <= 1'b0;
         sel_idx <= '0;
      end else if (wr_stb) begin
         sel_hit <= |code_match;
         sel_idx <= next_idx;
      end
   end

endmodule

// File: rtl/mbx_byte_store.sv
// Per-card ID byte stores with a dual byte read (addr, addr+1 wrapping).
module mbx_byte_store #(
   parameter  int NUM_CARDS = 3,
   parameter  int AW        = 6,
   parameter  int BYTE_W    = 8,
   localparam int IDX_W     = (NUM_CARDS > 1) ? $clog2(NUM_CARDS) : 1,
   localparam int DEPTH     = 1 << AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_card,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [BYTE_W-1:0] cfg_byte,
   input  logic [IDX_W-1:0]  rd_card,
   input  logic [AW-1:0]     rd_addr,
   output logic [BYTE_W-1:0] rd_hi,
   output logic [BYTE_W-1:0] rd_lo
);

   if (DEPTH * NUM_CARDS > 4096) begin : g_too_big
      $error("mbx_byte_store: store too large");
   end

   logic [AW-1:0] next_addr;
   assign next_addr = rd_addr + 1'b1;   // natural wrap inside the store

   logic [BYTE_W-1:0] card_hi [NUM_CARDS];
   logic [BYTE_W-1:0] card_lo [NUM_CARDS];

   for (genvar gc = 0; gc < NUM_CARDS; gc++) begin : g_card
      logic [BYTE_W-1:0] mem [DEPTH];
      logic              hit_we;

      assign hit_we = cfg_we && (cfg_card == IDX_W'(gc));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) begin
               mem[a] <= '1;    // erased contents
            end
         end else if (hit_we) begin
            mem[cfg_addr] <= cfg_byte;
         end
      end

      assign card_hi[gc] = mem[rd_addr];
      assign card_lo[gc] = mem[next_addr];
   end

   always_comb begin
      rd_hi = '1;
      rd_lo = '1;
      for (int i = 0; i < NUM_CARDS; i++) begin
         if (rd_card == IDX_W'(i)) begin
            rd_hi = card_hi[i];
            rd_lo = card_lo[i];
         end
      end
   end

endmodule

// File: rtl/card_id_mailbox.sv
module card_id_mailbox #(
   parameter  int NUM_CARDS = 3,
   parameter  int ADDR_W    = 8,
   parameter  int DATA_W    = 16,
   parameter  int STORE_AW  = 6,
   parameter  int BYTE_W    = 8,
   parameter  int CMD_WORDS = 2,
   localparam int IDX_W     = (NUM_CARDS > 1) ? $clog2(NUM_CARDS) : 1,
   localparam int PW        = (CMD_WORDS > 1) ? $clog2(CMD_WORDS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic                 cfg_byte_we,
   input  logic [IDX_W-1:0]     cfg_card,
   input  logic [STORE_AW-1:0]  cfg_addr,
   input  logic [BYTE_W-1:0]    cfg_byte,
   input  logic                 cfg_present_we,
   input  logic [NUM_CARDS-1:0] cfg_present
);

   import mbx_pkg::*;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("card_id_mailbox: ADDR_W must hold the register locations");
   end
   if (DATA_W < 2 * BYTE_W || DATA_W < NUM_CARDS) begin : g_bad_data
      $error("card_id_mailbox: DATA_W too narrow for the result word");
   end
   if (STORE_AW > DATA_W) begin : g_bad_store
      $error("card_id_mailbox: STORE_AW exceeds command word width");
   end

   localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(LOC_SELECT);
   localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(LOC_COMMAND);

   logic is_sel, is_cmd;
   assign is_sel = (bus_addr == A_SEL);
   assign is_cmd = (bus_addr == A_CMD);

   // ---------------- presence flags ----------------
   logic [NUM_CARDS-1:0] present;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         present <= '0;
      end else if (cfg_present_we) begin
         present <= cfg_present;
      end
   end

   // ---------------- select register ----------------
   logic             sel_hit;
   logic [IDX_W-1:0] sel_idx;

   mbx_sel_decode #(
      .NUM_CARDS (NUM_CARDS),
      .DATA_W    (DATA_W)
   ) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (bus_wr && is_sel),
      .wdata   (bus_wdata),
      .sel_hit (sel_hit),
      .sel_idx (sel_idx)
   );

   // ---------------- command sequencer ----------------
   logic                cmd_valid;
   logic [PW-1:0]       word_pos;
   logic [STORE_AW-1:0] byte_addr;

   mbx_cmd_seq #(
      .CMD_WORDS (CMD_WORDS),
      .AW        (STORE_AW)
   ) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (bus_wr && is_cmd),
      .rd_stb    (bus_rd && is_cmd),
      .addr_in   (bus_wdata[STORE_AW-1:0]),
      .cmd_valid (cmd_valid),
      .word_pos  (word_pos),
      .byte_addr (byte_addr)
   );

   // ---------------- ID byte stores ----------------
   logic [BYTE_W-1:0] rd_hi, rd_lo;

   mbx_byte_store #(
      .NUM_CARDS (NUM_CARDS),
      .AW        (STORE_AW),
      .BYTE_W    (BYTE_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_byte_we),
      .cfg_card (cfg_card),
      .cfg_addr (cfg_addr),
      .cfg_byte (cfg_byte),
      .rd_card  (sel_idx),
      .rd_addr  (byte_addr),
      .rd_hi    (rd_hi),
      .rd_lo    (rd_lo)
   );

   // ---------------- read data ----------------
   logic card_ok;

   always_comb begin
      card_ok = 1'b0;
      for (int i = 0; i < NUM_CARDS; i++) begin
         if (sel_hit && sel_idx == IDX_W'(i) && present[i]) begin
            card_ok = 1'b1;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (is_sel) begin
         bus_rdata = '1;
         bus_rdata[NUM_CARDS-1:0] = ~present;
      end else if (is_cmd) begin
         bus_rdata = '1;
         if (cmd_valid && card_ok) begin
            bus_rdata[2*BYTE_W-1:0] = {rd_hi, rd_lo};
         end
      end
   end

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
   parameter int NUM_CARDS = 3,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 16,
   parameter int CMD_WORDS = 2,
   parameter int PW        = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_wr,
   input logic                 bus_rd,
   input logic [DATA_W-1:0]    bus_rdata,
   input logic                 cmd_valid,
   input logic [PW-1:0]        word_pos,
   input logic [NUM_CARDS-1:0] present
);

   import mbx_pkg::*;

   localparam logic [PW-1:0] LAST_POS = PW'(CMD_WORDS - 1);

   logic at_sel, at_cmd, cmd_wr, cmd_rd, finishing;
   assign at_sel    = (bus_addr == ADDR_W'(LOC_SELECT));
   assign at_cmd    = (bus_addr == ADDR_W'(LOC_COMMAND));
   assign cmd_wr    = bus_wr && at_cmd;
   assign cmd_rd    = bus_rd && at_cmd;
   assign finishing = cmd_wr && (word_pos == LAST_POS);

   // R1: leaving reset, nothing pending and the counter at word 0
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!cmd_valid && word_pos == '0));

   // R2: the last command word makes the result pending
   a_r2_valid_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      finishing |=> cmd_valid);

   // R2: earlier words advance the counter by one
   a_r2_pos_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && word_pos != LAST_POS) |=> (word_pos == $past(word_pos) + 1'b1));

   // R3: a result read consumes the pending flag
   a_r3_consume: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rd && !finishing) |=> !cmd_valid);

   // R3: nothing pending reads as all ones
   a_r3_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rd && !cmd_valid) |-> (bus_rdata == '1));

   // R8: presence word is all ones with present cards cleared
   a_r8_presence: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && at_sel) |-> (bus_rdata == ~DATA_W'(present)));

   // R10: unknown locations read zero
   a_r10_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !at_sel && !at_cmd) |-> (bus_rdata == '0));

endmodule

bind card_id_mailbox mbx_checker #(
   .NUM_CARDS (NUM_CARDS),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .CMD_WORDS (CMD_WORDS),
   .PW        (PW)
) u_mbx_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .cmd_valid (cmd_valid),
   .word_pos  (word_pos),
   .present   (present)
);

// File: tb/card_id_mailbox_bench.sv
module card_id_mailbox_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        cfg_byte_we = 1'b0;
   logic [1:0]  cfg_card = '0;
   logic [5:0]  cfg_addr = '0;
   logic [7:0]  cfg_byte = '0;
   logic        cfg_present_we = 1'b0;
   logic [2:0]  cfg_present = '0;

   always #5 clk = ~clk;   // 100 MHz

   card_id_mailbox u_card_id_mailbox (
      .clk            (clk),
      .rst_n          (rst_n),
      .bus_addr       (bus_addr),
      .bus_wr         (bus_wr),
      .bus_rd         (bus_rd),
      .bus_wdata      (bus_wdata),
      .bus_rdata      (bus_rdata),
      .cfg_byte_we    (cfg_byte_we),
      .cfg_card       (cfg_card),
      .cfg_addr       (cfg_addr),
      .cfg_byte       (cfg_byte),
      .cfg_present_we (cfg_present_we),
      .cfg_present    (cfg_present)
   );

   typedef struct {
      logic [15:0] val;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 1'b0;

   localparam logic [7:0] SEL = 8'h12;
   localparam logic [7:0] CMD = 8'h42;

   // Bench's own ID contents per card
   function automatic logic [7:0] id_byte(input int c, input int a);
      case (c)
         0:       id_byte = 8'(a) ^ 8'h5A;
         1:       id_byte = 8'(a * 3);
         default: id_byte = 8'hC0 + 8'(a);
      endcase
   endfunction

   function automatic logic [15:0] id_word(input int c, input int a);
      id_word = {id_byte(c, a), id_byte(c, (a + 1) % 64)};
   endfunction

   task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   // Driver: pushes the expectation, strobes the read for one cycle
   task automatic bus_read(input logic [7:0] a, input logic [15:0] e, input string tag);
      exp_t x;
      x.val = e; x.tag = tag;
      @(posedge clk); #1;
      q.push_back(x);
      bus_addr = a; bus_rd = 1'b1;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic load_byte(input int c, input int a, input logic [7:0] b);
      @(posedge clk); #1;
      cfg_card = 2'(c); cfg_addr = 6'(a); cfg_byte = b; cfg_byte_we = 1'b1;
      @(posedge clk); #1;
      cfg_byte_we = 1'b0;
   endtask

   task automatic load_present(input logic [2:0] p);
      @(posedge clk); #1;
      cfg_present = p; cfg_present_we = 1'b1;
      @(posedge clk); #1;
      cfg_present_we = 1'b0;
   endtask

   task automatic run_cmd(input logic [15:0] w0, input logic [15:0] w1);
      bus_write(CMD, w0);
      bus_write(CMD, w1);
   endtask

   // Monitor: result is due in the strobe cycle itself (R9)
   always @(negedge clk) begin
      if (bus_rd && !done) begin
         if (q.size() == 0) begin
            fails++;
            $display("FAIL unexpected read: actual %h expected none", bus_rdata);
         end else begin
            exp_t x;
            x = q.pop_front();
            checks++;
            if (bus_rdata !== x.val) begin
               fails++;
               $display("FAIL %s: actual %h expected %h", x.tag, bus_rdata, x.val);
            end
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      bus_read(SEL, 16'hFFFF, "R1 presence after reset");
      bus_read(CMD, 16'hFFFF, "R1 result after reset");

      // R11 load stores and presence (card 2 absent)
      for (int c = 0; c < 3; c++) begin
         for (int a = 0; a < 64; a++) begin
            load_byte(c, a, id_byte(c, a));
         end
      end
      load_present(3'b011);
      bus_read(SEL, 16'hFFFC, "R8 R11 presence cards 0,1");

      // R4 R6 R9 card 0, address 5
      bus_write(SEL, 16'h1700);
      run_cmd(16'h0185, 16'h0000);
      bus_read(CMD, id_word(0, 5), "R4 R6 R9 card0 addr5");
      bus_read(CMD, 16'hFFFF, "R3 second read after consume");

      // R2 one word is not enough
      bus_write(CMD, 16'h018A);
      bus_read(CMD, 16'hFFFF, "R2 after single word");
      bus_write(CMD, 16'h0000);
      bus_read(CMD, id_word(0, 10), "R2 R11 after second word");

      // R6 wrap at the end of the store
      bus_write(SEL, 16'h1D00);
      run_cmd(16'h01BF, 16'h0000);
      bus_read(CMD, id_word(1, 63), "R6 wrap card1 addr63");

      // R5 upper bits and second word ignored
      run_cmd(16'h03EA, 16'hBEEF);
      bus_read(CMD, id_word(1, 42), "R5 address from low bits");

      // R7 absent card
      bus_write(SEL, 16'h3500);
      run_cmd(16'h0181, 16'h0000);
      bus_read(CMD, 16'hFFFF, "R7 card2 absent");

      load_present(3'b111);
      bus_read(SEL, 16'hFFF8, "R8 all present");
      run_cmd(16'h0181, 16'h0000);
      bus_read(CMD, id_word(2, 1), "R4 R7 card2 present");

      // R4 unknown select code
      bus_write(SEL, 16'h1701);
      run_cmd(16'h0181, 16'h0000);
      bus_read(CMD, 16'hFFFF, "R4 unknown select");

      // R10 other locations
      bus_read(8'h20, 16'h0000, "R10 other location reads zero");
      bus_write(SEL, 16'h1700);
      run_cmd(16'h0190, 16'h0000);
      bus_write(8'h13, 16'h1D00);
      bus_write(8'h43, 16'h0000);
      bus_read(CMD, id_word(0, 16), "R10 stray writes ignored");
      bus_read(SEL, 16'hFFF8, "R10 presence unchanged");

      repeat (3) @(posedge clk);
      if (q.size() != 0) begin
         fails++;
         $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
      end
      finish_run();
   end

endmodule